// File: doc/BRIEF.md
# Receive Buffer-Descriptor Chain DMA

This block stores incoming Ethernet frames in system memory for one receive channel. Software lays out a linked list of buffer descriptors in memory and writes the address of the first one into the head register. The block then reads each descriptor, writes the words of the next arriving frame into that descriptor's buffer, and writes a status word back into the descriptor. It then follows the link to the next descriptor. When the list ends, the channel stops and discards frames until software supplies a new head.

Each descriptor is four 32-bit words at byte offsets +0, +4, +8 and +12: link to the next descriptor, buffer address, buffer length in words (bits 15:0), and a flags/length word. Frames arrive as a stream of 32-bit words on a valid/ready interface. A word transfers on a cycle where both `in_valid` and `in_ready` are high. The block holds `in_ready` low while it fetches a descriptor, writes a data word, re-reads a link or writes status. The sender must then hold its word stable. While the channel is stopped, and while it waits for the next word of a frame, `in_ready` is high.

The memory port has a read channel and a write channel. Each is a request held until granted. Read data returns later, marked by `rd_rvalid`. A write is complete once its grant is seen.

Top module: `rx_chain_dma`

## Requirements
- R1: A nonzero write to the head register (register address 0) while the channel is stopped starts the channel. Its first four reads go to that address +0, +4, +8 and +12, in that order.
- R2: A head write of zero, or any head write while the channel is active, changes nothing. Reading register address 0 returns the descriptor currently in use.
- R3: Frame word k is written to buffer address + 4*k, in arrival order. Words that arrive before a word flagged start-of-frame are discarded.
- R4: Words past the buffer length are accepted and discarded, and nothing is written beyond the buffer. The recorded length is the smaller of the frame length in words and the buffer length.
- R5: If the link held in the current descriptor is zero at end of frame, the link word (offset +0) is read once more. If that read is still zero, end-of-queue is flagged and the channel stops. If it is nonzero, the channel continues at the address just read.
- R6: The status write goes to descriptor +12 and is issued after every data write of the frame. It holds start-of-packet in bit 31, end-of-packet in bit 30, ownership cleared in bit 29, end-of-queue in bit 28 and the length in bits 15:0. All other bits are zero.
- R7: `irq_pend` rises in the cycle after the status write is granted, whether or not end-of-queue was flagged.
- R8: `irq_pend` clears only on a write to register address 1 whose value equals the address of the last completed descriptor. Any other value leaves it set. Reading address 1 returns that descriptor address.
- R9: While the channel is stopped, frames are consumed whole with no memory access. Each dropped frame increments a 16-bit count read at register address 2.
- R10: A memory request that is not granted stays asserted in the next cycle, with its address and write data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame word valid |
| in_ready | output | 1 | Block can take a frame word |
| in_data | input | 32 | Frame word |
| in_sof | input | 1 | Word is the first of a frame |
| in_eof | input | 1 | Word is the last of a frame |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | AW | Read byte address |
| rd_gnt | input | 1 | Read request accepted |
| rd_rvalid | input | 1 | Read data returned |
| rd_rdata | input | 32 | Read data |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | AW | Write byte address |
| wr_data | output | 32 | Write data |
| wr_gnt | input | 1 | Write accepted and complete |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 head, 1 completion, 2 drop count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_pend | output | 1 | Completion pending flag |

## Verification
Checked on every cycle: the hold of ungranted memory requests, the bounds of data writes within the current buffer, end-of-queue appearing only after a zero re-read link, the pending flag following a granted status write, and the flag falling only after a matching completion write.

The bench scenarios show the rest:
- the read order of a fetch;
- the link being followed when software extends the list during a frame;
- ignored head writes;
- frame drops while stopped;
- the exact status words and buffer contents over a sweep of frame and buffer lengths.

// File: rtl/rxcd_pkg.sv
package rxcd_pkg;
  localparam int LEN_W = 16;

  localparam int FLG_SOP = 31;
  localparam int FLG_EOP = 30;
  localparam int FLG_OWN = 29;
  localparam int FLG_EOQ = 28;

  localparam logic [1:0] RA_HEAD = 2'd0;
  localparam logic [1:0] RA_CMPL = 2'd1;
  localparam logic [1:0] RA_DROP = 2'd2;

  typedef enum logic [2:0] {
    S_STOP,
    S_RD_REQ,
    S_RD_WAIT,
    S_RX,
    S_DWR,
    S_NXT_REQ,
    S_NXT_WAIT,
    S_WB
  } ch_state_t;
endpackage

// File: rtl/rxcd_regs.sv
module rxcd_regs
  import rxcd_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          busy,
  input  logic [AW-1:0] cur_desc,
  input  logic          wb_done,
  input  logic [AW-1:0] wb_addr,
  input  logic          drop_evt,
  output logic          start,
  output logic [AW-1:0] start_addr,
  output logic          irq_pend
);
  logic [AW-1:0] last_done;
  logic [CW-1:0] drops;
  logic          cmpl_hit;

  always_comb begin
    start_addr = reg_wdata[AW-1:0];
    start      = reg_wr && (reg_addr == RA_HEAD) && (start_addr != '0) && !busy;
    cmpl_hit   = reg_wr && (reg_addr == RA_CMPL) && (reg_wdata[AW-1:0] == last_done);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_done <= '0;
      irq_pend  <= 1'b0;
      drops     <= '0;
    end else begin
      if (wb_done) begin
        last_done <= wb_addr;
        irq_pend  <= 1'b1;
      end else if (cmpl_hit) begin
        irq_pend  <= 1'b0;
      end
      if (drop_evt) drops <= drops + 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_HEAD: reg_rdata = 32'(cur_desc);
      RA_CMPL: reg_rdata = 32'(last_done);
      RA_DROP: reg_rdata = 32'(drops);
      default: reg_rdata = 32'd0;
    endcase
  end

  p_pend_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> irq_pend);

  p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_pend) |-> $past(reg_wr && (reg_addr == RA_CMPL) &&
                              (reg_wdata[AW-1:0] == last_done)));
endmodule

// File: rtl/rxcd_ctrl.sv
module rxcd_ctrl
  import rxcd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic [AW-1:0] cur_desc,
  output logic          wb_done,
  output logic          drop_evt,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_gnt,
  input  logic          rd_rvalid,
  input  logic [31:0]   rd_rdata,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  input  logic          wr_gnt
);
  localparam logic [AW-1:0] OFS_FLAGS = AW'(12);

  ch_state_t        state;
  logic [AW-1:0]    cur, nxt, bufp, waddr_r;
  logic [LEN_W-1:0] blen, cnt, len_fin;
  logic [1:0]       idx;
  logic             eoq, eof_r, drop_mid;
  logic [31:0]      wdat_r, wb_word;
  logic             drop_path, take, rx_take;
  ch_state_t        after_eof;

  always_comb begin
    drop_path = (state == S_STOP) || drop_mid;
    in_ready  = drop_path || (state == S_RX);
    take      = in_valid && in_ready;
    rx_take   = take && !drop_path;
    drop_evt  = take && drop_path && in_eof;
    busy      = (state != S_STOP);
    cur_desc  = cur;
    after_eof = (nxt == '0) ? S_NXT_REQ : S_WB;

    len_fin = (cnt < blen) ? cnt : blen;
    wb_word = 32'(len_fin);
    wb_word[FLG_SOP] = 1'b1;
    wb_word[FLG_EOP] = 1'b1;
    wb_word[FLG_OWN] = 1'b0;
    wb_word[FLG_EOQ] = eoq;

    rd_req  = (state == S_RD_REQ) || (state == S_NXT_REQ);
    rd_addr = (state == S_NXT_REQ) ? cur : cur + AW'({idx, 2'b00});
    wr_req  = (state == S_DWR) || (state == S_WB);
    wr_addr = (state == S_WB) ? cur + OFS_FLAGS : waddr_r;
    wr_data = (state == S_WB) ? wb_word : wdat_r;
    wb_done = (state == S_WB) && wr_gnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_mid <= 1'b0;
    end else if (take && drop_path) begin
      drop_mid <= !in_eof;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_STOP;
      cur     <= '0;
      nxt     <= '0;
      bufp    <= '0;
      blen    <= '0;
      cnt     <= '0;
      idx     <= '0;
      eoq     <= 1'b0;
      eof_r   <= 1'b0;
      waddr_r <= '0;
      wdat_r  <= '0;
    end else begin
      case (state)
        S_STOP: begin
          if (start) begin
            cur   <= start_addr;
            idx   <= '0;
            state <= S_RD_REQ;
          end
        end
        S_RD_REQ: if (rd_gnt) state <= S_RD_WAIT;
        S_RD_WAIT: begin
          if (rd_rvalid) begin
            case (idx)
              2'd0:    nxt  <= rd_rdata[AW-1:0];
              2'd1:    bufp <= rd_rdata[AW-1:0];
              2'd2:    blen <= rd_rdata[LEN_W-1:0];
              default: ;
            endcase
            if (idx == 2'd3) begin
              cnt   <= '0;
              state <= S_RX;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_RD_REQ;
            end
          end
        end
        S_RX: begin
          if (rx_take && !((cnt == '0) && !in_sof)) begin
            if (cnt != '1) cnt <= cnt + 1'b1;
            if (cnt < blen) begin
              waddr_r <= bufp + AW'({cnt, 2'b00});
              wdat_r  <= in_data;
              eof_r   <= in_eof;
              state   <= S_DWR;
            end else if (in_eof) begin
              eoq   <= 1'b0;
              state <= after_eof;
            end
          end
        end
        S_DWR: begin
          if (wr_gnt) begin
            if (eof_r) begin
              eoq   <= 1'b0;
              state <= after_eof;
            end else begin
              state <= S_RX;
            end
          end
        end
        S_NXT_REQ: if (rd_gnt) state <= S_NXT_WAIT;
        S_NXT_WAIT: begin
          if (rd_rvalid) begin
            nxt   <= rd_rdata[AW-1:0];
            eoq   <= (rd_rdata[AW-1:0] == '0);
            state <= S_WB;
          end
        end
        S_WB: begin
          if (wr_gnt) begin
            if (eoq) begin
              state <= S_STOP;
            end else begin
              cur   <= nxt;
              idx   <= '0;
              state <= S_RD_REQ;
            end
          end
        end
        default: state <= S_STOP;
      endcase
    end
  end

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr)));

  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_gnt) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  p_in_buffer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DWR) |-> ((wr_addr - bufp) < AW'({blen, 2'b00})));

  p_eoq_reread_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_gnt && wr_data[FLG_EOQ] && (state == S_WB)) |-> (nxt == '0));
endmodule

// File: rtl/rx_chain_dma.sv
module rx_chain_dma #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_gnt,
  input  logic          rd_rvalid,
  input  logic [31:0]   rd_rdata,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  input  logic          wr_gnt,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq_pend
);
  logic          start, busy, wb_done, drop_evt;
  logic [AW-1:0] start_addr, cur_desc;

  rxcd_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .cur_desc(cur_desc), .wb_done(wb_done), .wb_addr(cur_desc),
    .drop_evt(drop_evt), .start(start), .start_addr(start_addr), .irq_pend(irq_pend)
  );

  rxcd_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_addr(start_addr), .busy(busy), .cur_desc(cur_desc),
    .wb_done(wb_done), .drop_evt(drop_evt),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_gnt(wr_gnt)
  );
endmodule

// File: tb/rx_chain_dma_bench.sv
module rx_chain_dma_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        rd_req, wr_req, rd_gnt, wr_gnt;
  logic        rd_rvalid = 1'b0;
  logic [31:0] rd_rdata = '0;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq_pend;

  rx_chain_dma u_rx_chain_dma (.*);

  logic [31:0] mem [0:255];
  logic [2:0]  gctr = '0;
  logic        poke_en = 1'b0;
  logic [31:0] poke_a = '0, poke_d = '0;
  logic [31:0] rd_log [0:31];
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_wr_addr = '0;
  int          n_cmp = 0, n_bad = 0;

  assign rd_gnt = (gctr != 3'd2);
  assign wr_gnt = (gctr != 3'd5);

  always @(posedge clk) begin
    gctr <= gctr + 3'd1;
    rd_rvalid <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else begin
      if (rd_req && rd_gnt) begin
        rd_rvalid <= 1'b1;
        rd_rdata  <= mem[rd_addr[9:2]];
        if (rd_cnt < 32) rd_log[rd_cnt] <= rd_addr;
        rd_cnt <= rd_cnt + 1;
      end
      if (wr_req && wr_gnt) begin
        mem[wr_addr[9:2]] <= wr_data;
        wr_cnt <= wr_cnt + 1;
        last_wr_addr <= wr_addr;
      end
      if (poke_en) mem[poke_a[9:2]] <= poke_d;
    end
  end

  function automatic logic [31:0] fw(input int tag, input int k);
    return 32'hA500_0000 | (32'(tag) << 8) | 32'(k);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic set_desc(input logic [31:0] a, nx, bf, bl);
    poke(a, nx); poke(a + 4, bf); poke(a + 8, bl); poke(a + 12, 32'h2000_0000);
  endtask

  task automatic send_frame(input int len, input int tag);
    logic acc;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fw(tag, k); in_sof = (k == 0); in_eof = (k == len - 1);
      do begin
        acc = in_ready;
        if (!acc) @(negedge clk);
      end while (!acc);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic wait_done(input logic [31:0] d);
    int t = 0;
    while (mem[(d + 12) >> 2][29] && t < 3000) begin @(negedge clk); t++; end
    if (t >= 3000) check("R6 own-clear timeout", 32'd1, 32'd0);
    @(negedge clk);
  endtask

  task automatic wait_rd(input int n);
    int t = 0;
    while (rd_cnt < n && t < 3000) begin @(negedge clk); t++; end
    if (t >= 3000) check("R1 fetch timeout", 32'(rd_cnt), 32'(n));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    int w0, r0, m, seq;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R7 reset pend", 32'(irq_pend), 32'd0);
    check("R9 reset ready", 32'(in_ready), 32'd1);
    check("R10 reset rd_req", 32'(rd_req), 32'd0);
    reg_read(2'd2, r); check("R9 reset drops", r, 32'd0);

    // R9: frame while stopped is dropped
    send_frame(3, 1);
    repeat (4) @(negedge clk);
    reg_read(2'd2, r); check("R9 drop count", r, 32'd1);
    check("R9 no writes while stopped", 32'(wr_cnt), 32'd0);

    // R2: head write of zero ignored
    reg_write(2'd0, 32'd0);
    repeat (10) @(negedge clk);
    check("R2 zero head no fetch", 32'(rd_cnt), 32'd0);

    set_desc(32'h40, 32'h50, 32'h200, 32'd4);
    set_desc(32'h50, 32'h60, 32'h240, 32'd4);
    set_desc(32'h60, 32'h00, 32'h280, 32'd4);
    set_desc(32'h70, 32'h00, 32'h2C0, 32'd4);
    poke(32'h250, 32'h5E5E_0004);

    reg_write(2'd0, 32'h40);
    wait_rd(4);
    for (int i = 0; i < 4; i++) check("R1 fetch order", rd_log[i], 32'h40 + 32'(4 * i));

    send_frame(3, 2);
    wait_done(32'h40);
    for (int i = 0; i < 3; i++) check("R3 data word", mem[(32'h200 >> 2) + i], fw(2, i));
    check("R6 status D0", mem[(32'h40 + 12) >> 2], 32'hC000_0003);
    check("R7 pend after wb", 32'(irq_pend), 32'd1);
    reg_read(2'd1, r); check("R8 last desc", r, 32'h40);

    // R2: head write while active ignored
    reg_write(2'd0, 32'h60);
    reg_read(2'd0, r); check("R2 active head ignored", r, 32'h50);
    wait_rd(8);
    check("R2 fetch follows link", rd_log[4], 32'h50);

    // R8: completion pointer handling
    reg_write(2'd1, 32'h50);
    check("R8 mismatch keeps pend", 32'(irq_pend), 32'd1);
    reg_write(2'd1, 32'h40);
    check("R8 match clears pend", 32'(irq_pend), 32'd0);

    // R4: truncation
    send_frame(6, 3);
    wait_done(32'h50);
    for (int i = 0; i < 4; i++) check("R4 truncated data", mem[(32'h240 >> 2) + i], fw(3, i));
    check("R4 no write past buffer", mem[32'h250 >> 2], 32'h5E5E_0004);
    check("R4 status length", mem[(32'h50 + 12) >> 2], 32'hC000_0004);

    // R5: link extended during frame, re-read picks it up
    wait_rd(12);
    poke(32'h60, 32'h70);
    send_frame(2, 4);
    wait_done(32'h60);
    check("R5 extended no eoq", mem[(32'h60 + 12) >> 2], 32'hC000_0002);
    check("R5 reread addr", rd_log[12], 32'h60);
    wait_rd(17);
    check("R5 continue at new link", rd_log[13], 32'h70);

    send_frame(5, 5);
    wait_done(32'h70);
    check("R5 eoq status", mem[(32'h70 + 12) >> 2], 32'hD000_0004);
    check("R5 final reread", rd_log[17], 32'h70);
    check("R7 pend with eoq", 32'(irq_pend), 32'd1);
    reg_read(2'd1, r); check("R8 last desc eoq", r, 32'h70);

    // R9: stopped after eoq
    w0 = wr_cnt; r0 = rd_cnt;
    send_frame(3, 6);
    repeat (6) @(negedge clk);
    reg_read(2'd2, r); check("R9 drop after eoq", r, 32'd2);
    check("R9 no write after eoq", 32'(wr_cnt), 32'(w0));
    check("R9 no read after eoq", 32'(rd_cnt), 32'(r0));

    // sweep frame length x buffer length
    seq = 16;
    for (int L = 1; L <= 6; L++) begin
      for (int B = 1; B <= 4; B++) begin
        for (int i = 0; i < 8; i++) poke(32'h300 + 32'(4 * i), 32'h5E00_0000 | 32'(i));
        set_desc(32'h100, 32'h0, 32'h300, 32'(B));
        w0 = wr_cnt;
        reg_write(2'd0, 32'h100);
        send_frame(L, seq);
        wait_done(32'h100);
        m = (L < B) ? L : B;
        check("R6 sweep status", mem[(32'h100 + 12) >> 2], 32'hD000_0000 | 32'(m));
        for (int i = 0; i < 8; i++)
          check("R3 R4 sweep buffer", mem[(32'h300 >> 2) + i],
                (i < m) ? fw(seq, i) : (32'h5E00_0000 | 32'(i)));
        check("R6 sweep write count", 32'(wr_cnt - w0), 32'(m + 1));
        check("R6 status written last", last_wr_addr, 32'h10C);
        seq++;
      end
    end
    reg_write(2'd1, 32'h100);
    check("R8 final clear", 32'(irq_pend), 32'd0);

    summary();
    $finish;
  end
endmodule